// File: doc/BRIEF.md
# Sequential Floating-Point Multiplier

This block multiplies two floating-point operands over several clock cycles. Each operand packs a sign bit, a biased exponent field and a magnitude fraction. The fraction is read as a binary fraction whose point lies to the left of its most significant bit, and a nonzero operand is normalized, so that bit is 1. Zero is the encoding whose exponent and fraction are both all zeros. The exponent bias is 2^(EXP_W-1)-1.

A request is a one-cycle `start` pulse with the operands on `op_a` and `op_b`. If either operand is zero, the block skips the arithmetic and returns zero on the next cycle. Otherwise it adds the two biased exponents and removes one bias, and it forms the fraction product by repeated add-and-shift, one multiplier bit per cycle, into a double-length register. A final pass normalizes the product. Two normalized fractions have a product of at least one quarter, so this pass needs no more than one left shift. The result is truncated to the fraction width. There is no rounding, no special values and no exponent range flags.

Top module: `seq_fp_mul`

## Requirements
- R1: An operand whose exponent and fraction fields are both zero is zero. If either operand is zero, `result` is all zeros, sign included, and `done` is high in the cycle after the edge that samples `start`.
- R2: The result sign (bit EXP_W+MAN_W) is the XOR of the two operand sign bits.
- R3: When the top bit of the 2·MAN_W-bit fraction product is 1, the result exponent (bits EXP_W+MAN_W-1 down to MAN_W) is exp_a + exp_b − (2^(EXP_W-1)−1), taken modulo 2^EXP_W.
- R4: When the top product bit is 1, the result fraction (bits MAN_W-1 down to 0) is the upper MAN_W bits of the product, truncated.
- R5: When the top product bit is 0, the product is shifted left by one before the upper MAN_W bits are taken, and the exponent from R3 is decreased by one. The result fraction of a nonzero product always has its top bit set.
- R6: For two nonzero operands, `done` rises after MAN_W+2 rising edges, counting the edge that samples `start` as the first.
- R7: `done` is high for exactly one cycle, and `result` keeps its value until the next `done`.
- R8: `busy` is high from an accepted nonzero request until `done`. A `start` that arrives while `busy` is high is ignored and does not change the result in progress.
- R9: While `rst_n` is low, `busy`, `done` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled while idle |
| op_a | input | 1+EXP_W+MAN_W | Multiplicand {sign, biased exponent, fraction} |
| op_b | input | 1+EXP_W+MAN_W | Multiplier {sign, biased exponent, fraction} |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse when result is valid |
| result | output | 1+EXP_W+MAN_W | Normalized, truncated product |

## Verification
A zero-operand product is due one edge after the edge that samples `start`. A nonzero product is due after MAN_W+2 edges: the sampling edge, MAN_W add-and-shift steps and one normalize edge. For every request the bench counts edges from the sampling edge until it sees `done` at a falling edge, and it checks that count against the expected value before it compares `result` with a product from its own model. It then checks at later falling edges that `done` has dropped and that `result` has held its value.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
   typedef enum logic [1:0] {
      FPM_IDLE = 2'd0,
      FPM_MUL  = 2'd1,
      FPM_NORM = 2'd2
   } fpm_state_t;
endpackage

// File: rtl/fpm_exp_path.sv
module fpm_exp_path #(
   parameter int EXP_W = 8
) (
   input  logic [EXP_W-1:0] exp_a,
   input  logic [EXP_W-1:0] exp_b,
   output logic [EXP_W-1:0] exp_sum
);
   localparam logic [EXP_W-1:0] BIAS = EXP_W'((1 << (EXP_W-1)) - 1);

   // two biased values summed carry the bias twice; remove one copy
   always_comb exp_sum = exp_a + exp_b - BIAS;
endmodule

// File: rtl/fpm_mant_seq.sv
module fpm_mant_seq #(
   parameter int MAN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [MAN_W-1:0] frac_a,
   input  logic [MAN_W-1:0] frac_b,
   output logic [MAN_W:0]   prod_hi,
   output logic             last
);
   localparam int CW = $clog2(MAN_W + 1);
   localparam logic [CW-1:0] LAST_CNT = CW'(MAN_W - 1);

   logic [MAN_W-1:0] acc, mq, mcand;
   logic [CW-1:0]    cnt;
   logic [MAN_W:0]   sum;

   always_comb sum = {1'b0, acc} + (mq[0] ? {1'b0, mcand} : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc   <= '0;
         mq    <= '0;
         mcand <= '0;
         cnt   <= '0;
      end else if (load) begin
         acc   <= '0;
         mq    <= frac_b;
         mcand <= frac_a;
         cnt   <= '0;
      end else if (step) begin
         acc <= sum[MAN_W:1];
         mq  <= {sum[0], mq[MAN_W-1:1]};
         cnt <= cnt + 1'b1;
      end
   end

   always_comb last    = (cnt == LAST_CNT);
   always_comb prod_hi = {acc, mq[MAN_W-1]};

   p_step_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> cnt <= LAST_CNT);
   p_step_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/fpm_norm.sv
module fpm_norm #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 16
) (
   input  logic [MAN_W:0]   prod_hi,
   input  logic [EXP_W-1:0] exp_in,
   output logic [MAN_W-1:0] frac_out,
   output logic [EXP_W-1:0] exp_out
);
   // a product of two fractions in [1/2,1) lies in [1/4,1): one shift at most
   always_comb begin
      if (prod_hi[MAN_W]) begin
         frac_out = prod_hi[MAN_W:1];
         exp_out  = exp_in;
      end else begin
         frac_out = prod_hi[MAN_W-1:0];
         exp_out  = exp_in - 1'b1;
      end
   end
endmodule

// File: rtl/seq_fp_mul.sv
module seq_fp_mul #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 16,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] result
);
   import fpm_pkg::*;

   generate
      if (EXP_W < 3) begin : g_bad_exp
         $error("seq_fp_mul: EXP_W must be at least 3");
      end
      if (MAN_W < 2) begin : g_bad_man
         $error("seq_fp_mul: MAN_W must be at least 2");
      end
   endgenerate

   fpm_state_t st;
   logic             zero_in, accept, sgn_q, last;
   logic [EXP_W-1:0] ea_q, eb_q, e_sum, e_fin;
   logic [MAN_W:0]   prod_hi;
   logic [MAN_W-1:0] f_fin;

   always_comb zero_in = (op_a[W-2:0] == '0) || (op_b[W-2:0] == '0);
   always_comb accept  = start && (st == FPM_IDLE);

   fpm_exp_path #(.EXP_W(EXP_W)) u_exp (
      .exp_a(ea_q), .exp_b(eb_q), .exp_sum(e_sum));

   fpm_mant_seq #(.MAN_W(MAN_W)) u_mant (
      .clk(clk), .rst_n(rst_n),
      .load(accept && !zero_in), .step(st == FPM_MUL),
      .frac_a(op_a[MAN_W-1:0]), .frac_b(op_b[MAN_W-1:0]),
      .prod_hi(prod_hi), .last(last));

   fpm_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
      .prod_hi(prod_hi), .exp_in(e_sum), .frac_out(f_fin), .exp_out(e_fin));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= FPM_IDLE;
         done   <= 1'b0;
         result <= '0;
         sgn_q  <= 1'b0;
         ea_q   <= '0;
         eb_q   <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            FPM_IDLE: if (start) begin
               if (zero_in) begin
                  result <= '0;
                  done   <= 1'b1;
               end else begin
                  sgn_q <= op_a[W-1] ^ op_b[W-1];
                  ea_q  <= op_a[W-2:MAN_W];
                  eb_q  <= op_b[W-2:MAN_W];
                  st    <= FPM_MUL;
               end
            end
            FPM_MUL:  if (last) st <= FPM_NORM;
            FPM_NORM: begin
               result <= {sgn_q, e_fin, f_fin};
               done   <= 1'b1;
               st     <= FPM_IDLE;
            end
            default:  st <= FPM_IDLE;
         endcase
      end
   end

   always_comb busy = (st != FPM_IDLE);

   p_zero_fast_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && zero_in) |=> done && result == '0);
   p_norm_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result[W-2:0] != '0) |-> result[MAN_W-1]);
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));
   p_busy_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   p_busy_to_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
endmodule

// File: tb/sim_seq_fp_mul.sv
module sim_seq_fp_mul;
   localparam int EW = 8;
   localparam int MW = 16;
   localparam int W  = 1 + EW + MW;
   localparam int NV = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0;
   logic busy, done;
   logic [W-1:0] result;

   int checks = 0;
   int bad = 0;
   bit timed_out = 1'b0;

   always #2.5 clk = ~clk;

   seq_fp_mul #(.EXP_W(EW), .MAN_W(MW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .busy(busy), .done(done), .result(result));

   // stimulus pairs {a, b}; a = {sign, exp, frac}
   localparam logic [2*W-1:0] VEC [NV] = '{
      {1'b0, 8'd127, 16'h8000, 1'b0, 8'd127, 16'h8000},
      {1'b0, 8'd130, 16'hFFFF, 1'b0, 8'd120, 16'hFFFF},
      {1'b1, 8'd100, 16'hC000, 1'b0, 8'd140, 16'hC000},
      {1'b1, 8'd127, 16'hA5A5, 1'b1, 8'd127, 16'h8001},
      {1'b0, 8'd0,   16'h0000, 1'b1, 8'd150, 16'hF000},
      {1'b1, 8'd77,  16'h9ABC, 1'b1, 8'd0,   16'h0000},
      {1'b0, 8'd200, 16'hB6DB, 1'b1, 8'd60,  16'hE38E},
      {1'b0, 8'd1,   16'h8000, 1'b0, 8'd255, 16'hFFFF}
   };

   function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [2*MW-1:0] p;
      logic [EW-1:0]   e;
      if (a[W-2:0] == '0 || b[W-2:0] == '0) return '0;
      p = {{MW{1'b0}}, a[MW-1:0]} * {{MW{1'b0}}, b[MW-1:0]};
      e = a[W-2:MW] + b[W-2:MW] - EW'(127);
      if (p[2*MW-1]) return {a[W-1] ^ b[W-1], e, p[2*MW-1:MW]};
      return {a[W-1] ^ b[W-1], e - 1'b1, p[2*MW-2:MW-1]};
   endfunction

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, output int lat);
      @(negedge clk);
      op_a = a; op_b = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      #200000;
      timed_out = 1'b1;
      checks++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      int lat;
      logic [W-1:0] e, held;
      repeat (3) @(negedge clk);
      // R9: outputs held at zero in reset
      check(busy == 0 && done == 0 && result == '0, "R9 reset", W'({busy, done}) | result, '0);
      rst_n = 1'b1;

      // table walk: R1 R2 R3 R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         logic [W-1:0] a, b;
         bit z;
         a = VEC[i][2*W-1:W];
         b = VEC[i][W-1:0];
         z = (a[W-2:0] == '0) || (b[W-2:0] == '0);
         e = model(a, b);
         run(a, b, lat);
         check(lat == (z ? 1 : MW + 2), z ? "R1 zero latency" : "R6 latency",
               W'(lat), W'(z ? 1 : MW + 2));
         check(result == e, z ? "R1 zero result" : "R2 R3 R4 R5 product", result, e);
      end

      // R5: 0.5*0.5 needs the shift and exponent decrement
      run({1'b0, 8'd127, 16'h8000}, {1'b0, 8'd127, 16'h8000}, lat);
      check(result == {1'b0, 8'd126, 16'h8000}, "R5 shift", result, {1'b0, 8'd126, 16'h8000});
      // R3 R4: no shift case with known value 0.75*0.75 = 0.5625
      run({1'b0, 8'd130, 16'hC000}, {1'b0, 8'd127, 16'hC000}, lat);
      check(result == {1'b0, 8'd130, 16'h9000}, "R3 R4 no shift", result, {1'b0, 8'd130, 16'h9000});

      // R7: done drops next cycle, result holds
      held = result;
      @(negedge clk);
      check(done == 1'b0, "R7 done pulse", W'(done), '0);
      repeat (5) @(negedge clk);
      check(result == held, "R7 hold", result, held);

      // R8: start while busy is ignored
      e = model({1'b1, 8'd140, 16'hF0F0}, {1'b0, 8'd110, 16'h8888});
      @(negedge clk);
      op_a = {1'b1, 8'd140, 16'hF0F0}; op_b = {1'b0, 8'd110, 16'h8888}; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R8 busy", W'(busy), W'(1));
      repeat (3) @(negedge clk);
      op_a = '0; op_b = {1'b0, 8'd5, 16'h8000}; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 5;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      check(lat == MW + 2, "R8 latency unchanged", W'(lat), W'(MW + 2));
      check(result == e, "R8 ignored start", result, e);
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R8 idle after", W'({busy, done}), '0);

      // R9: reset mid operation
      run({1'b0, 8'd127, 16'hFFFF}, {1'b0, 8'd127, 16'h8000}, lat);
      @(negedge clk);
      op_a = {1'b0, 8'd127, 16'hAAAA}; op_b = {1'b0, 8'd127, 16'hAAAA}; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check(busy == 0 && done == 0 && result == '0, "R9 reset mid op", result, '0);

      if (!timed_out) begin
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule